// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider setting of one phase-locked loop without letting a glitched clock reach the logic the loop feeds. A requester presents the reference divider, the feedback multiplier and the output divider together with a one-cycle start strobe. The sequencer captures the request. It then steps the loop's control fields through a safe order: bypass to the reference and hold the loop in reset, write the divider fields, hold reset for a settle time, release reset, poll the lock flag, and finally return the loop to normal mode.

The divider fields use a minus-one encoding. The bandwidth-adjust field is derived from the multiplier so the loop keeps its nominal bandwidth. All waits are counted in microseconds by a tick divider that runs from the reference clock. If lock does not appear within a bounded number of polls, the sequencer leaves the loop in bypass and reports an error. With a 24 MHz reference, the loop's VCO runs at 24 MHz × NF / NR and the output is the VCO divided by NO.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, or a reset applied in mid-sequence, the outputs are: `pll_slow`=1, `pll_rst`=0, `busy`=0, `done`=0, `lock_err`=0, and all four field outputs are zero.
- R2: A start accepted while idle gives `busy`=1, `pll_slow`=1 and `pll_rst`=1 in the next cycle. The field outputs still hold their previous values in that cycle.
- R3: One cycle later the fields are loaded as value minus one: `fld_nr`=NR-1, `fld_od`=NO-1, `fld_nf`=NF-1.
- R4: In the same cycle `fld_bw` is loaded with floor(NF/2)-1, using NF_W-1 bits (NF is at least 2).
- R5: `pll_rst` stays high with the new fields in place for exactly SETTLE_US×CYC_PER_US cycles and then falls. `pll_slow` is still 1 when it falls.
- R6: After reset is released, the lock input is sampled once every CYC_PER_US cycles, with the first sample CYC_PER_US cycles after release. The first sample that sees lock sets `pll_slow`=0 and raises `done`. Lock present before release does not shorten the settle hold.
- R7: If none of the first LOCK_TMO_US samples sees lock, `done` rises with `lock_err`=1 and `pll_slow` stays 1. A lock seen at the last allowed sample counts as success.
- R8: A start raised while `busy`=1 is ignored: the fields, the timing and the outcome of the running sequence are unchanged.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. `lock_err` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_nr | input | NR_W | Requested reference divider (1 or more) |
| req_nf | input | NF_W | Requested feedback multiplier (2 or more) |
| req_no | input | NO_W | Requested output divider (1 or more) |
| pll_lock | input | 1 | Lock flag from the loop |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_err | output | 1 | Last sequence timed out waiting for lock |
| pll_slow | output | 1 | 1 = bypass to reference, 0 = normal mode |
| pll_rst | output | 1 | Loop reset |
| fld_nr | output | NR_W | Reference divider field (NR-1) |
| fld_od | output | NO_W | Output divider field (NO-1) |
| fld_nf | output | NF_W | Feedback divider field (NF-1) |
| fld_bw | output | NF_W-1 | Bandwidth adjust field (NF/2-1) |

## Verification
The lock success path and the timeout path can fall on the same microsecond tick. This happens when lock first becomes visible at the last poll the timeout allows. The bench provokes it by raising lock one cycle before that final sample. It expects `done` at exactly LOCK_TMO_US×CYC_PER_US cycles after release, with `lock_err`=0 and normal mode. A lock raised one cycle later must produce the timeout result at the same cycle instead. A second collision is a start strobe that arrives while a sequence is running. The bench injects new divider values mid-poll and checks that the fields and the completion cycle of the running sequence do not change.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ENTER  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_POLL   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_us_timer.sv
module seq_us_timer #(
  parameter int CYC_PER_US = 24,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic             us_tick,
  output logic [CNT_W-1:0] us_cnt
);
  localparam int CYC_W = (CYC_PER_US > 2) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

  logic [CYC_W-1:0] cyc_q;

  assign us_tick = (cyc_q == CYC_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cyc_q  <= '0;
      us_cnt <= '0;
    end else if (us_tick) begin
      cyc_q  <= '0;
      us_cnt <= us_cnt + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_field_regs.sv
module seq_field_regs #(
  parameter int NR_W = 6,
  parameter int NF_W = 13,
  parameter int NO_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            load,
  input  logic [NR_W-1:0] req_nr,
  input  logic [NF_W-1:0] req_nf,
  input  logic [NO_W-1:0] req_no,
  output logic [NR_W-1:0] fld_nr,
  output logic [NO_W-1:0] fld_od,
  output logic [NF_W-1:0] fld_nf,
  output logic [NF_W-2:0] fld_bw
);
  localparam int BW_W = NF_W - 1;

  logic [NR_W-1:0] hold_nr;
  logic [NF_W-1:0] hold_nf;
  logic [NO_W-1:0] hold_no;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_nr <= '0;
      hold_nf <= '0;
      hold_no <= '0;
    end else if (capture) begin
      hold_nr <= req_nr;
      hold_nf <= req_nf;
      hold_no <= req_no;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_nr <= '0;
      fld_od <= '0;
      fld_nf <= '0;
      fld_bw <= '0;
    end else if (load) begin
      fld_nr <= hold_nr - 1'b1;
      fld_od <= hold_no - 1'b1;
      fld_nf <= hold_nf - 1'b1;
      fld_bw <= hold_nf[NF_W-1:1] - BW_W'(1);
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US   = 10,
  parameter int LOCK_TMO_US = 1000,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pll_lock,
  input  logic             us_tick,
  input  logic [CNT_W-1:0] us_cnt,
  output logic             accept,
  output logic             load,
  output logic             tmr_clr,
  output logic             busy,
  output logic             done,
  output logic             lock_err,
  output logic             pll_slow,
  output logic             pll_rst
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);
  localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(LOCK_TMO_US - 1);

  seq_state_t state_q;
  logic settle_end;
  logic last_poll;

  assign accept     = (state_q == ST_IDLE) && start;
  assign load       = (state_q == ST_ENTER);
  assign settle_end = (state_q == ST_SETTLE) && us_tick && (us_cnt == SETTLE_LAST);
  assign last_poll  = us_tick && (us_cnt == POLL_LAST);
  assign tmr_clr    = !((state_q == ST_SETTLE) || (state_q == ST_POLL)) || settle_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      lock_err <= 1'b0;
      pll_slow <= 1'b1;
      pll_rst  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_ENTER;
            busy     <= 1'b1;
            lock_err <= 1'b0;
            pll_slow <= 1'b1;
            pll_rst  <= 1'b1;
          end
        end
        ST_ENTER: state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (settle_end) begin
            pll_rst <= 1'b0;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (us_tick && pll_lock) begin
            pll_slow <= 1'b0;
            done     <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end else if (last_poll) begin
            lock_err <= 1'b1;
            done     <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int CYC_PER_US  = 24,
  parameter int SETTLE_US   = 10,
  parameter int LOCK_TMO_US = 1000,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NR_W-1:0] req_nr,
  input  logic [NF_W-1:0] req_nf,
  input  logic [NO_W-1:0] req_no,
  input  logic            pll_lock,
  output logic            busy,
  output logic            done,
  output logic            lock_err,
  output logic            pll_slow,
  output logic            pll_rst,
  output logic [NR_W-1:0] fld_nr,
  output logic [NO_W-1:0] fld_od,
  output logic [NF_W-1:0] fld_nf,
  output logic [NF_W-2:0] fld_bw
);
  localparam int US_MAX = (SETTLE_US > LOCK_TMO_US) ? SETTLE_US : LOCK_TMO_US;
  localparam int CNT_W  = $clog2(US_MAX + 1);

  logic             accept;
  logic             load;
  logic             tmr_clr;
  logic             us_tick;
  logic [CNT_W-1:0] us_cnt;

  seq_us_timer #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .us_tick(us_tick), .us_cnt(us_cnt)
  );

  seq_ctrl #(.SETTLE_US(SETTLE_US), .LOCK_TMO_US(LOCK_TMO_US), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pll_lock(pll_lock),
    .us_tick(us_tick), .us_cnt(us_cnt), .accept(accept), .load(load),
    .tmr_clr(tmr_clr), .busy(busy), .done(done), .lock_err(lock_err),
    .pll_slow(pll_slow), .pll_rst(pll_rst)
  );

  seq_field_regs #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)) u_fields (
    .clk(clk), .rst(rst), .capture(accept), .load(load),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no),
    .fld_nr(fld_nr), .fld_od(fld_od), .fld_nf(fld_nf), .fld_bw(fld_bw)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int NR_W = 6,
  parameter int NF_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            pll_lock,
  input logic            busy,
  input logic            done,
  input logic            lock_err,
  input logic            pll_slow,
  input logic            pll_rst,
  input logic [NR_W-1:0] fld_nr,
  input logic [NF_W-1:0] fld_nf
);
  p_start_enters_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && pll_rst && pll_slow));

  p_fields_move_in_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(fld_nr) || !$stable(fld_nf)) |-> pll_rst);

  p_reset_only_in_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    pll_rst |-> pll_slow);

  p_normal_after_lock_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_slow) |-> ($past(pll_lock) && done));

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_err) |-> (done && pll_slow));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy || done));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind pll_reprog_seq pll_seq_chk #(.NR_W(NR_W), .NF_W(NF_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .pll_lock(pll_lock), .busy(busy),
  .done(done), .lock_err(lock_err), .pll_slow(pll_slow), .pll_rst(pll_rst),
  .fld_nr(fld_nr), .fld_nf(fld_nf)
);

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
  localparam int C    = 4;
  localparam int S    = 10;
  localparam int T    = 8;
  localparam int NR_W = 6;
  localparam int NF_W = 13;
  localparam int NO_W = 4;
  localparam int NV   = 6;

  localparam int V_NR  [NV] = '{12, 1,  1,  3,  2,  63};
  localparam int V_NF  [NV] = '{100, 68, 50, 255, 64, 8191};
  localparam int V_NO  [NV] = '{2,  2,  6,  1,  4,  15};
  localparam int V_D   [NV] = '{5,  0,  13, 31, 32, 9};
  localparam bit V_ERR [NV] = '{0,  0,  0,  0,  1,  0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pll_lock = 1'b0;
  logic [NR_W-1:0] req_nr = '0;
  logic [NF_W-1:0] req_nf = '0;
  logic [NO_W-1:0] req_no = '0;
  logic busy, done, lock_err, pll_slow, pll_rst;
  logic [NR_W-1:0] fld_nr;
  logic [NO_W-1:0] fld_od;
  logic [NF_W-1:0] fld_nf;
  logic [NF_W-2:0] fld_bw;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  pll_reprog_seq #(
    .CYC_PER_US(C), .SETTLE_US(S), .LOCK_TMO_US(T),
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)
  ) i_pll_reprog_seq (
    .clk(clk), .rst(rst), .start(start), .req_nr(req_nr), .req_nf(req_nf),
    .req_no(req_no), .pll_lock(pll_lock), .busy(busy), .done(done),
    .lock_err(lock_err), .pll_slow(pll_slow), .pll_rst(pll_rst),
    .fld_nr(fld_nr), .fld_od(fld_od), .fld_nf(fld_nf), .fld_bw(fld_bw)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pack_ctl();
    return {busy, done, lock_err, pll_slow, pll_rst};
  endfunction

  task automatic check_reset_state(input string tag);
    chk(pack_ctl() == 5'b00010, tag, pack_ctl(), 5'b00010);
    chk({fld_nr, fld_od, fld_nf, fld_bw} == '0, tag,
        {fld_nr, fld_od, fld_nf, fld_bw}, 0);
  endtask

  task automatic run_seq(input int nr, input int nf, input int no, input int d,
                         input bit exp_err, input bit early, input bit poke);
    int n;
    int cnt;
    int k;
    int exp_n;
    logic [NR_W-1:0] old_nr;
    logic [NF_W-1:0] old_nf;
    logic [NR_W-1:0] e_nr;
    logic [NO_W-1:0] e_od;
    logic [NF_W-1:0] e_nf;
    logic [NF_W-2:0] e_bw;
    old_nr = fld_nr;
    old_nf = fld_nf;
    e_nr = NR_W'(nr - 1);
    e_od = NO_W'(no - 1);
    e_nf = NF_W'(nf - 1);
    e_bw = (NF_W-1)'(nf / 2 - 1);
    @(negedge clk);
    req_nr = NR_W'(nr); req_nf = NF_W'(nf); req_no = NO_W'(no);
    start = 1'b1;
    pll_lock = early;
    @(negedge clk);
    start = 1'b0;
    req_nr = '0; req_nf = '0; req_no = '0;
    chk(busy && pll_rst && pll_slow, "R2 enter bypass+reset", pack_ctl(), 5'b10011);
    chk(fld_nr == old_nr && fld_nf == old_nf, "R2 fields not yet loaded", fld_nr, old_nr);
    @(negedge clk);
    chk(fld_nr == e_nr && fld_od == e_od && fld_nf == e_nf, "R3 minus-one fields",
        {fld_nr, fld_od, fld_nf}, {e_nr, e_od, e_nf});
    chk(fld_bw == e_bw, "R4 bandwidth field", fld_bw, e_bw);
    cnt = 0;
    while (pll_rst && cnt < 10000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == S * C, "R5 settle hold length", cnt, S * C);
    chk(pll_slow && busy, "R5 still bypassed at release", pll_slow, 1);
    k = early ? 1 : (d / C + 1);
    exp_n = (k > T) ? T * C : k * C;
    n = 0;
    while (1) begin
      if (!early && n == d) pll_lock = 1'b1;
      if (poke && n == 1) begin
        start = 1'b1; req_nr = 6'd7; req_nf = 13'd999; req_no = 4'd3;
      end
      if (poke && n == 2) start = 1'b0;
      if (done || n > T * C + 4) break;
      @(negedge clk);
      n++;
    end
    if (exp_err)
      chk(n == exp_n, "R7 timeout completion cycle", n, exp_n);
    else
      chk(n == exp_n, "R6 lock poll completion cycle", n, exp_n);
    chk(done && !busy, "R9 done with busy low", pack_ctl(), 5'b01000);
    chk(lock_err == exp_err, "R7 error flag", lock_err, exp_err);
    chk(pll_slow == exp_err && !pll_rst, "R6 final mode", pll_slow, exp_err);
    if (poke)
      chk(fld_nr == e_nr && fld_nf == e_nf && fld_od == e_od, "R8 busy start ignored",
          fld_nr, e_nr);
    pll_lock = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    chk(lock_err == exp_err, "R9 error held", lock_err, exp_err);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("R1 reset state");

    for (int i = 0; i < NV; i++)
      run_seq(V_NR[i], V_NF[i], V_NO[i], V_D[i], V_ERR[i], 1'b0, 1'b0);

    // R9: error from the timeout above is cleared by the next accepted start
    run_seq(5, 40, 2, 2, 1'b0, 1'b0, 1'b0);
    // R6: lock already high before release does not shorten the hold
    run_seq(4, 96, 3, 0, 1'b0, 1'b1, 1'b0);
    // R8: start pulsed mid-poll with other values
    run_seq(9, 120, 5, 10, 1'b0, 1'b0, 1'b1);
    // R7: lock arriving exactly one cycle late for the last poll
    run_seq(2, 30, 2, T * C, 1'b1, 1'b0, 1'b0);
    // R7: lock arriving in time for the last poll wins over the timeout
    run_seq(2, 30, 2, T * C - 1, 1'b0, 1'b0, 1'b0);

    // R1: reset in mid-sequence
    @(negedge clk);
    req_nr = 6'd3; req_nf = 13'd60; req_no = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("R1 mid-sequence reset");
    run_seq(3, 60, 2, 6, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule